// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block listens to the write side of a parallel flash command bus: an active-low write strobe, a word address and a byte of data. Each input passes through a synchroniser into the system clock. The block follows the six-write command protocol that a NOR-style flash uses to start an erase. A full chip-erase sequence raises a one-clock chip-erase request. A full sector-erase sequence raises a one-clock sector-erase request, and the number of the chosen sector travels with that request. A write that does not match the expected step sends the decoder back to idle, and no request is issued.

After a sector request, the decoder stays in a batching mode for as long as an external window signal is high. In this mode a single sector-erase write queues one more sector, without a repeat of the five preamble writes. While the busy input is high, the device is running an erase, and every write is ignored.

The erase algorithm is outside this block, and so are the timing of the window, the status reporting and the storage array.

Top module: `erase_cmd_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `chip_req` and `sect_req` are 0, `sect_num` is 0 and the decoder is idle.
- R2: A write takes its address from the bus as it stood at the falling edge of `we_n`. It takes its data from the bus as it stood at the rising edge of `we_n`. The address may change while the strobe is low and the write is still taken.
- R3: The chip-erase sequence is six writes, given as data@address: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555. It produces exactly one `chip_req` pulse. Only address bits [10:0] are compared.
- R4: The same five preamble writes, followed by data 0x30 at any address, produce one `sect_req` pulse. With that pulse, `sect_num` equals the top SECT_W bits of the sixth write's address.
- R5: A write whose data or address bits [10:0] do not match the expected step returns the decoder to idle with no request. That write is not taken as the first step of a new sequence.
- R6: After a sector request, while `batch_open` is high, a single write of data 0x30 at any address issues another `sect_req` with that address's sector. A write of 0xB0 keeps batching without a request. Any other write ends batching, and the decoder returns to idle.
- R7: When `batch_open` is low, batching mode ends. A single 0x30 write then gives no request.
- R8: While `busy` is high, completed writes are ignored. The decoder neither advances nor falls back, so a sequence interrupted by a busy-time write still completes afterwards.
- R9: Each request is a single-clock pulse, and `chip_req` and `sect_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Asynchronous active-low write strobe |
| addr | input | ADDR_W | Asynchronous word address bus |
| data | input | 8 | Asynchronous command data bus |
| busy | input | 1 | High while an internal erase runs; writes ignored |
| batch_open | input | 1 | High while the sector batching window is open |
| chip_req | output | 1 | One-clock chip-erase request |
| sect_req | output | 1 | One-clock sector-erase request |
| sect_num | output | SECT_W | Sector number carried with `sect_req` |

## Verification
The decoder is driven with whole chip-erase and sector-erase sequences whose unused upper address bits are random. This separates the bits that are compared from those that are ignored. Some writes change the address while the strobe is low and present the data only just before the strobe rises, which shows which edge latches each bus. Sequences broken at a given step, batch writes with the window open and closed, and preamble writes made while busy separate abort from ignore. A long run of random writes, biased toward correct next steps, checks every write against a reference model of the protocol.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;

    localparam int CMD_AW = 11;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] A_KEY_HI = 11'h555;
    localparam logic [CMD_AW-1:0] A_KEY_LO = 11'h2AA;

    localparam logic [CMD_DW-1:0] D_KEY_HI = 8'hAA;
    localparam logic [CMD_DW-1:0] D_KEY_LO = 8'h55;
    localparam logic [CMD_DW-1:0] D_ARM    = 8'h80;
    localparam logic [CMD_DW-1:0] D_CHIP   = 8'h10;
    localparam logic [CMD_DW-1:0] D_SECT   = 8'h30;
    localparam logic [CMD_DW-1:0] D_HOLD   = 8'hB0;

    // state name = number of preamble writes already accepted
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_ARMED,
        ST_KEY3,
        ST_KEY4,
        ST_BATCH
    } dec_state_e;

    typedef struct packed {
        logic [CMD_AW-1:0] a;
        logic [CMD_DW-1:0] d;
    } cmd_t;

    function automatic cmd_t step_cmd(input dec_state_e s);
        cmd_t c;
        case (s)
            ST_IDLE, ST_ARMED: c = '{a: A_KEY_HI, d: D_KEY_HI};
            ST_KEY1, ST_KEY3:  c = '{a: A_KEY_LO, d: D_KEY_LO};
            ST_KEY2:           c = '{a: A_KEY_HI, d: D_ARM};
            default:           c = '{a: A_KEY_HI, d: D_CHIP};
        endcase
        return c;
    endfunction

    function automatic dec_state_e step_next(input dec_state_e s);
        dec_state_e n;
        case (s)
            ST_IDLE:  n = ST_KEY1;
            ST_KEY1:  n = ST_KEY2;
            ST_KEY2:  n = ST_ARMED;
            ST_ARMED: n = ST_KEY3;
            ST_KEY3:  n = ST_KEY4;
            default:  n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/erase_wr_sync.sv
module erase_wr_sync
    import erase_cmd_pkg::*;
#(
    parameter int KEEP_W = 14,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_n,
    input  logic [KEEP_W-1:0] addr,
    input  logic [CMD_DW-1:0] data,
    output logic              wr_valid,
    output logic [KEEP_W-1:0] wr_addr,
    output logic [CMD_DW-1:0] wr_data
);
    logic [SYNC_N-1:0] we_pipe;
    logic [KEEP_W-1:0] addr_pipe [SYNC_N];
    logic [CMD_DW-1:0] data_pipe [SYNC_N];
    logic              we_prev;
    logic [KEEP_W-1:0] addr_lat;
    logic              we_s, fall_det, rise_det;

    assign we_s     = we_pipe[SYNC_N-1];
    assign fall_det = we_prev & ~we_s;
    assign rise_det = ~we_prev & we_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_pipe <= '1;
            we_prev <= 1'b1;
        end else begin
            we_pipe <= {we_pipe[SYNC_N-2:0], we_n};
            we_prev <= we_s;
        end
    end

    generate
        for (genvar i = 0; i < SYNC_N; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        addr_pipe[i] <= '0;
                        data_pipe[i] <= '0;
                    end else begin
                        addr_pipe[i] <= addr;
                        data_pipe[i] <= data;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) begin
                        addr_pipe[i] <= '0;
                        data_pipe[i] <= '0;
                    end else begin
                        addr_pipe[i] <= addr_pipe[i-1];
                        data_pipe[i] <= data_pipe[i-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lat <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            if (fall_det) addr_lat <= addr_pipe[SYNC_N-1];
            wr_valid <= rise_det;
            if (rise_det) begin
                wr_addr <= addr_lat;
                wr_data <= data_pipe[SYNC_N-1];
            end
        end
    end
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_cmd_pkg::*;
#(
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [CMD_AW-1:0] wr_cmd_addr,
    input  logic [SECT_W-1:0] wr_sect,
    input  logic [CMD_DW-1:0] wr_data,
    input  logic              busy,
    input  logic              batch_open,
    output logic              chip_req,
    output logic              sect_req,
    output logic [SECT_W-1:0] sect_num,
    output dec_state_e        state
);
    dec_state_e state_n;
    logic       take, chip_n, sect_n;
    cmd_t       want;

    assign take = wr_valid & ~busy;
    assign want = step_cmd(state);

    always_comb begin
        state_n = state;
        chip_n  = 1'b0;
        sect_n  = 1'b0;
        case (state)
            ST_BATCH: begin
                if (!batch_open) begin
                    state_n = ST_IDLE;
                end else if (take) begin
                    if (wr_data == D_SECT)      sect_n  = 1'b1;
                    else if (wr_data != D_HOLD) state_n = ST_IDLE;
                end
            end
            ST_KEY4: begin
                if (take) begin
                    if (wr_data == D_CHIP && wr_cmd_addr == A_KEY_HI) begin
                        chip_n  = 1'b1;
                        state_n = ST_IDLE;
                    end else if (wr_data == D_SECT) begin
                        sect_n  = 1'b1;
                        state_n = ST_BATCH;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: begin
                if (take) begin
                    state_n = (wr_data == want.d && wr_cmd_addr == want.a)
                              ? step_next(state) : ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            chip_req <= 1'b0;
            sect_req <= 1'b0;
            sect_num <= '0;
        end else begin
            state    <= state_n;
            chip_req <= chip_n;
            sect_req <= sect_n;
            if (sect_n) sect_num <= wr_sect;
        end
    end
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_DW-1:0] data,
    input  logic              busy,
    input  logic              batch_open,
    output logic              chip_req,
    output logic              sect_req,
    output logic [SECT_W-1:0] sect_num
);
    localparam int KEEP_W = SECT_W + CMD_AW;

    logic [KEEP_W-1:0] addr_keep;
    logic [KEEP_W-1:0] wr_addr;
    logic [CMD_DW-1:0] wr_data;
    logic              wr_valid;
    dec_state_e        dec_state;

    assign addr_keep = {addr[ADDR_W-1 -: SECT_W], addr[CMD_AW-1:0]};

    generate
        if (ADDR_W - SECT_W > CMD_AW) begin : g_mid
            logic mid_unused;
            assign mid_unused = ^addr[ADDR_W-SECT_W-1:CMD_AW];
        end
    endgenerate

    erase_wr_sync #(.KEEP_W(KEEP_W), .SYNC_N(SYNC_N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .we_n     (we_n),
        .addr     (addr_keep),
        .data     (data),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    erase_seq_fsm #(.SECT_W(SECT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_cmd_addr (wr_addr[CMD_AW-1:0]),
        .wr_sect     (wr_addr[KEEP_W-1 -: SECT_W]),
        .wr_data     (wr_data),
        .busy        (busy),
        .batch_open  (batch_open),
        .chip_req    (chip_req),
        .sect_req    (sect_req),
        .sect_num    (sect_num),
        .state       (dec_state)
    );
endmodule

// File: rtl/erase_cmd_chk.sv
module erase_cmd_chk
    import erase_cmd_pkg::*;
#(
    parameter int SECT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              batch_open,
    input logic              chip_req,
    input logic              sect_req,
    input logic [SECT_W-1:0] sect_num,
    input logic              wr_valid,
    input logic [SECT_W-1:0] wr_sect,
    input dec_state_e        state
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!chip_req && !sect_req && sect_num == '0 && state == ST_IDLE));

    // R9
    chip_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chip_req |=> !chip_req);

    // R9
    sect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sect_req |=> !sect_req);

    // R9
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(chip_req && sect_req));

    // R8
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_req || sect_req) |-> ($past(wr_valid) && !$past(busy)));

    // R4
    sect_carry_chk: assert property (@(posedge clk) disable iff (rst)
        sect_req |-> (sect_num == $past(wr_sect)));

    // R7
    batch_window_chk: assert property (@(posedge clk) disable iff (rst)
        sect_req |-> ($past(state) == ST_KEY4 || $past(batch_open)));
endmodule

bind erase_cmd_decoder erase_cmd_chk #(.SECT_W(SECT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .batch_open (batch_open),
    .chip_req   (chip_req),
    .sect_req   (sect_req),
    .sect_num   (sect_num),
    .wr_valid   (wr_valid),
    .wr_sect    (wr_addr[KEEP_W-1 -: SECT_W]),
    .state      (dec_state)
);

// File: tb/tb_erase_cmd_decoder.sv
module tb_erase_cmd_decoder;
    localparam int AW = 19;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;
    logic          busy = 1'b0;
    logic          batch_open = 1'b0;
    logic          chip_req, sect_req;
    logic [SW-1:0] sect_num;

    int n_cmp = 0, n_bad = 0;
    int chip_cnt = 0, sect_cnt = 0;
    logic [SW-1:0] last_sect = '0;
    int ms = 0;   // model: 0..5 preamble writes accepted, 6 batching
    bit done = 0;

    always #5 clk = ~clk;

    erase_cmd_decoder #(.ADDR_W(AW), .SECT_W(SW)) dut (
        .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .data(data),
        .busy(busy), .batch_open(batch_open), .chip_req(chip_req),
        .sect_req(sect_req), .sect_num(sect_num)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (chip_req) chip_cnt++;
            if (sect_req) begin
                sect_cnt++;
                last_sect = sect_num;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] m_addr(input int s);
        case (s)
            0, 3:    return 11'h555;
            1, 4:    return 11'h2AA;
            default: return 11'h555;
        endcase
    endfunction

    function automatic logic [7:0] m_data(input int s);
        case (s)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    // reference model of the protocol; e: 0 none, 1 chip, 2 sector
    task automatic model_step(input logic [AW-1:0] a, input logic [7:0] d,
                              input bit bsy, output int e);
        e = 0;
        if (bsy) return;                        // R8
        if (ms == 6) begin                      // R6
            if (d == 8'h30) e = 2;
            else if (d != 8'hB0) ms = 0;
        end else if (ms == 5) begin
            if (d == 8'h10 && a[10:0] == 11'h555) begin e = 1; ms = 0; end
            else if (d == 8'h30) begin e = 2; ms = batch_open ? 6 : 0; end
            else ms = 0;
        end else begin                          // R5
            ms = (a[10:0] == m_addr(ms) && d == m_data(ms)) ? ms + 1 : 0;
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                            input bit bsy, input string req);
        int c0, s0, e;
        c0 = chip_cnt;
        s0 = sect_cnt;
        model_step(a, d, bsy, e);
        @(negedge clk);
        busy = bsy;
        addr = a;
        data = 8'($urandom);
        @(negedge clk);
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = AW'($urandom);                   // R2: address moves while low
        data = d;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        data = 8'($urandom);                    // R2: data moves after rise
        repeat (5) @(negedge clk);
        busy = 1'b0;
        check(chip_cnt - c0 == (e == 1 ? 1 : 0), {req, " chip pulses"}, chip_cnt - c0, e == 1 ? 1 : 0);
        check(sect_cnt - s0 == (e == 2 ? 1 : 0), {req, " sector pulses"}, sect_cnt - s0, e == 2 ? 1 : 0);
        if (e == 2)
            check(last_sect == a[AW-1 -: SW], {req, " sector number"}, int'(last_sect), int'(a[AW-1 -: SW]));
    endtask

    task automatic set_win(input bit w);
        @(negedge clk);
        batch_open = w;
        if (!w && ms == 6) ms = 0;              // R7
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] up(input logic [10:0] lo);
        logic [AW-1:0] r;
        r = AW'($urandom);
        r[10:0] = lo;
        return r;
    endfunction

    task automatic preamble(input string req);
        for (int i = 0; i < 5; i++) do_write(up(m_addr(i)), m_data(i), 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        // R1
        check(chip_req == 1'b0 && sect_req == 1'b0, "R1 requests in reset", int'({chip_req, sect_req}), 0);
        check(sect_num == '0, "R1 sector in reset", int'(sect_num), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(chip_req == 1'b0 && sect_req == 1'b0, "R1 requests after reset", int'({chip_req, sect_req}), 0);

        // R3 chip erase with random upper address bits
        preamble("R3");
        do_write(up(11'h555), 8'h10, 1'b0, "R3");
        // R3 near miss on address low bits
        preamble("R3");
        do_write(up(11'h554), 8'h10, 1'b0, "R3");

        // R4 and R2: sector erase, address moved while strobe low
        preamble("R4");
        do_write(19'h5_1234, 8'h30, 1'b0, "R2 R4");

        // R6 batching with window open
        set_win(1'b1);
        preamble("R6");
        do_write(19'h2_0000, 8'h30, 1'b0, "R6");
        do_write(19'h7_FFFF, 8'h30, 1'b0, "R6");
        do_write(19'h0_0555, 8'hB0, 1'b0, "R6");
        do_write(19'h6_0001, 8'h30, 1'b0, "R6");
        do_write(19'h6_0001, 8'h80, 1'b0, "R6");
        do_write(19'h1_0000, 8'h30, 1'b0, "R6");

        // R7 window closed ends batching
        preamble("R7");
        do_write(19'h3_0000, 8'h30, 1'b0, "R7");
        set_win(1'b0);
        do_write(19'h4_0000, 8'h30, 1'b0, "R7");

        // R5 mismatch at step three, remainder of a sequence gives nothing
        do_write(up(11'h555), 8'hAA, 1'b0, "R5");
        do_write(up(11'h2AA), 8'h55, 1'b0, "R5");
        do_write(up(11'h555), 8'h81, 1'b0, "R5");
        for (int i = 3; i < 5; i++) do_write(up(m_addr(i)), m_data(i), 1'b0, "R5");
        do_write(up(11'h555), 8'h10, 1'b0, "R5");

        // R8 busy write inside a sequence is ignored
        do_write(up(11'h555), 8'hAA, 1'b0, "R8");
        do_write(up(11'h2AA), 8'h55, 1'b0, "R8");
        do_write(up(11'h123), 8'hFF, 1'b1, "R8");
        for (int i = 2; i < 5; i++) do_write(up(m_addr(i)), m_data(i), 1'b0, "R8");
        do_write(19'h6_ABCD, 8'h30, 1'b0, "R8");
        do_write(19'h6_ABCD, 8'h55, 1'b0, "R8");

        // constrained random: mostly correct next steps, some noise
        for (int k = 0; k < 400; k++) begin
            int pick;
            bit bsy;
            pick = int'($urandom_range(0, 99));
            bsy  = ($urandom_range(0, 9) == 0);
            if (pick < 4) set_win(~batch_open);
            if (pick < 70) begin
                if (ms == 6 || (ms == 5 && pick < 35))
                    do_write(AW'($urandom), (pick % 5 == 0) ? 8'hB0 : 8'h30, bsy, "R6 R4 random");
                else
                    do_write(up(m_addr(ms)), m_data(ms), bsy, "R3 R5 random");
            end else begin
                do_write(AW'($urandom), 8'($urandom), bsy, "R5 R8 random");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule